// File: doc/BRIEF.md
# Peripheral-Shared GPIO Port

An eight-pin I/O port that lets each pin be lent to an on-chip peripheral or kept under software control. Four registers sit on a simple synchronous bus (address, write enable, write data, combinational read data): a pin-ownership mask, a direction mask, a data register and a pullup mask. For every pin the port picks between the peripheral's output value and output enable and the software-driven path, and drives the pad output, pad output enable and pullup enable.

Pad inputs pass through a two-flop synchronizer before they are read back or forwarded to the peripheral. Data read-back depends on ownership: a software-owned pin always reads its synchronized pad level, so an overdriven output shows the real level. A peripheral-owned pin reads the stored data bit if its direction bit is set, and the pad level if not. The data register keeps its contents whatever the owner is. Software can therefore preload a value before taking a pin, and the pin drives that value from the first cycle it is owned.

Top module: `gpio_share_port`

## Requirements
- R1: After reset, the owner, direction, data and pullup registers read 0x00, pad_pu_o is 0x00, and pad_out_o/pad_oe_o follow periph_out_i/periph_oe_i.
- R2: Register offsets are owner = 0, direction = 1, data = 2, pullup = 3. A write takes effect at the clock edge that samples we_i. rdata_o is combinational from addr_i. The owner, direction and pullup registers read back what was written.
- R3: For a pin whose owner bit is 0, pad_out_o and pad_oe_o equal periph_out_i and periph_oe_i. Writes to the data register do not change that pin's pad outputs.
- R4: For a pin whose owner bit is 1, pad_oe_o equals the direction bit and pad_out_o equals the data register bit.
- R5: For a pin whose owner bit is 1, the data read returns the synchronized pad level for both directions, even when it differs from the written value.
- R6: For a pin whose owner bit is 0, the data read returns the stored data bit when the direction bit is 1, and the synchronized pad level when it is 0.
- R7: periph_in_o is 0 for a pin whose owner bit is 1, and the synchronized pad level for a pin whose owner bit is 0.
- R8: A change on pad_in_i reaches periph_in_o and the data read after exactly two rising clock edges, and not after one.
- R9: Each pad_pu_o bit equals its pullup register bit, whatever the owner bit, and changes only on a write to offset 3.
- R10: If data is written before the owner bit is set, pad_out_o shows the preloaded value in the first cycle after the owner write.
- R11: With owner = 0xC7 and direction = 0xC0, bits 7-6 drive the data register, bits 2-0 are undriven inputs and bits 5-3 follow the peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register offset |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| periph_out_i | input | 8 | Peripheral output value per pin |
| periph_oe_i | input | 8 | Peripheral output enable per pin |
| periph_in_o | output | 8 | Synchronized pad level to the peripheral |
| pad_in_i | input | 8 | Pad input level |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| pad_pu_o | output | 8 | Pad pullup enable |

## Verification
The assertions treat pad_in_i as a level that is sampled at clock edges. Their synchronizer-latency check needs the value two edges back to be defined. The bench therefore drives pad_in_i and all bus inputs only at falling edges and holds them from time zero. The ownership checks fire only on a write of all-zero or all-one masks, so the bench uses both forms as well as mixed masks. The bench also relies on the bus being used only one write per cycle with a fixed address.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_OWNER = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_PULL  = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_share_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  owner_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  pull_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_o <= '0;
      dir_o   <= '0;
      data_o  <= '0;
      pull_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_OWNER: owner_o <= wdata_i;
        OFS_DIR:   dir_o   <= wdata_i;
        OFS_DATA:  data_o  <= wdata_i;
        OFS_PULL:  pull_o  <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] owner_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  input  logic [WIDTH-1:0] periph_out_i,
  input  logic [WIDTH-1:0] periph_oe_i,
  output logic [WIDTH-1:0] periph_in_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] data_rd_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    always_comb begin
      if (owner_i[b]) begin
        pad_out_o[b]   = data_i[b];
        pad_oe_o[b]    = dir_i[b];
        periph_in_o[b] = 1'b0;
        data_rd_o[b]   = pin_sync_i[b];
      end else begin
        pad_out_o[b]   = periph_out_i[b];
        pad_oe_o[b]    = periph_oe_i[b];
        periph_in_o[b] = pin_sync_i[b];
        // peripheral-owned outputs read the latch, inputs read the pad
        data_rd_o[b]   = dir_i[b] ? data_i[b] : pin_sync_i[b];
      end
    end
  end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  periph_out_i,
  input  logic [WIDTH-1:0]  periph_oe_i,
  output logic [WIDTH-1:0]  periph_in_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_pu_o
);
  logic [WIDTH-1:0] owner_q, dir_q, data_q, pull_q, pin_sync, data_rd;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .owner_o(owner_q), .dir_o(dir_q), .data_o(data_q), .pull_o(pull_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_sync)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .owner_i(owner_q), .dir_i(dir_q), .data_i(data_q), .pin_sync_i(pin_sync),
    .periph_out_i, .periph_oe_i, .periph_in_o, .pad_out_o, .pad_oe_o,
    .data_rd_o(data_rd)
  );

  assign pad_pu_o = pull_q;

  always_comb begin
    unique case (addr_i)
      OFS_OWNER: rdata_o = owner_q;
      OFS_DIR:   rdata_o = dir_q;
      OFS_DATA:  rdata_o = data_rd;
      OFS_PULL:  rdata_o = pull_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_share_chk.sv
module gpio_share_chk
  import gpio_share_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  periph_out_i,
  input logic [WIDTH-1:0]  periph_oe_i,
  input logic [WIDTH-1:0]  periph_in_o,
  input logic [WIDTH-1:0]  pad_in_i,
  input logic [WIDTH-1:0]  pad_out_o,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [WIDTH-1:0]  pad_pu_o
);
  p_pull_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_PULL) |=> pad_pu_o == $past(wdata_i));

  p_pull_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_PULL) |=> $stable(pad_pu_o));

  p_periph_own_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_OWNER && wdata_i == '0)
    |=> (pad_out_o == periph_out_i && pad_oe_o == periph_oe_i));

  p_gpio_blocks_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_OWNER && wdata_i == '1) |=> periph_in_o == '0);

  p_sync_depth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_in_o & ~$past(pad_in_i, 2)) == '0);
endmodule

bind gpio_share_port gpio_share_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_gpio_share_port.sv
module sim_gpio_share_port;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, we = 0;
  logic [1:0] addr = '0;
  logic [W-1:0] wdata = '0, pout = '0, poe = '0, pad = '0;
  logic [W-1:0] rdata, pin, out, oe, pu;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_share_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .periph_out_i(pout), .periph_oe_i(poe), .periph_in_o(pin),
    .pad_in_i(pad), .pad_out_o(out), .pad_oe_o(oe), .pad_pu_o(pu)
  );

  // owner, dir, data, pad, pout, poe, exp_out, exp_oe, exp_rd, exp_pin
  typedef logic [W-1:0] vec_t [10];
  localparam vec_t VECS [6] = '{
    '{8'h00, 8'h00, 8'h00, 8'hA5, 8'h3C, 8'hF0, 8'h3C, 8'hF0, 8'hA5, 8'hA5},
    '{8'hFF, 8'hFF, 8'h5A, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'hFF, 8'h5A, 8'h00},
    '{8'hFF, 8'hF0, 8'hAA, 8'h0F, 8'h00, 8'h00, 8'hAA, 8'hF0, 8'h0F, 8'h00},
    '{8'h00, 8'hFF, 8'h96, 8'h00, 8'h11, 8'h22, 8'h11, 8'h22, 8'h96, 8'h00},
    '{8'hC7, 8'hC0, 8'h80, 8'h2D, 8'h38, 8'h10, 8'hB8, 8'hD0, 8'h2D, 8'h28},
    '{8'h0F, 8'h33, 8'hC3, 8'h99, 8'hF0, 8'h0F, 8'hF3, 8'h03, 8'h89, 8'h90}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    pout = 8'h6E; poe = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 owner", v, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd3, v); chk("R1 pull", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 pu", pu, 8'h00);
    chk("R1 out", out, 8'h6E);
    chk("R1 oe", oe, 8'h81);

    // table: R3 R4 R5 R6 R7 R11
    foreach (VECS[i]) begin
      pad = VECS[i][3]; pout = VECS[i][4]; poe = VECS[i][5];
      wr(2'd2, VECS[i][2]);
      wr(2'd1, VECS[i][1]);
      wr(2'd0, VECS[i][0]);
      repeat (2) @(negedge clk);
      chk($sformatf("R4/R3/R11 out v%0d", i), out, VECS[i][6]);
      chk($sformatf("R4/R3/R11 oe v%0d", i), oe, VECS[i][7]);
      rd(2'd2, v); chk($sformatf("R5/R6 rd v%0d", i), v, VECS[i][8]);
      chk($sformatf("R7 pin v%0d", i), pin, VECS[i][9]);
    end

    // R2 readback and write timing
    wr(2'd1, 8'h3E);
    rd(2'd1, v); chk("R2 dir readback", v, 8'h3E);
    rd(2'd0, v); chk("R2 owner readback", v, 8'h0F);
    @(negedge clk); addr = 2'd3; we = 1; wdata = 8'hA1; #1;
    chk("R2 pull before edge", pu, 8'h00);
    @(negedge clk); we = 0;
    chk("R2 R9 pull after edge", pu, 8'hA1);

    // R9 pullup independent of owner, held across other writes
    wr(2'd0, 8'hFF); chk("R9 pu gpio", pu, 8'hA1);
    wr(2'd0, 8'h00); chk("R9 pu periph", pu, 8'hA1);

    // R3 data write ignored at pads while peripheral-owned
    pout = 8'h5C; poe = 8'hC5;
    wr(2'd2, 8'hFF);
    chk("R3 out ignores data", out, 8'h5C);
    chk("R3 oe ignores data", oe, 8'hC5);

    // R8 two-edge latency (owner 0)
    wr(2'd1, 8'h00);
    pad = 8'h00; repeat (3) @(negedge clk);
    pad = 8'hC3;
    @(negedge clk); chk("R8 one edge", pin, 8'h00);
    @(negedge clk); chk("R8 two edges", pin, 8'hC3);
    rd(2'd2, v); chk("R8 data read", v, 8'hC3);

    // R10 preload then take ownership
    wr(2'd2, 8'h3C);
    wr(2'd1, 8'hFF);
    chk("R10 before owner", out, 8'h5C);
    @(negedge clk); addr = 2'd0; we = 1; wdata = 8'hFF;
    @(posedge clk); #1;
    chk("R10 first cycle", out, 8'h3C);
    @(negedge clk); we = 0;

    finish_run();
  end
endmodule